// File: doc/BRIEF.md
# DMA Stream Byte-Reorder and Data Signature Stage

This stage sits inside a DMA channel on the word stream between the bus and the block it serves. It can reverse the byte order of every word, so a producer or consumer of the other endianness, or a bus lane wired in the wrong order, is corrected in hardware. While the words pass, it also folds each one into two running signatures: a CRC-32 and a 32-bit additive checksum.

Firmware reads both signatures and compares them with the signatures that another instance took on the same data. For example, it can compare the values taken when one block wrote a buffer with those taken when another block read it back, to find where data was corrupted. Every instance uses the same algorithms. A direction input marks which side of the stage is the bus side, and the signatures are always taken on the word as it appears there.

The output word is held in a register. Ready passes combinationally from downstream, so the stage accepts one word on every clock for as long as the consumer keeps up.

Top module: `dma_swap_sig`

## Requirements
- R1: After reset, out_valid is 0, crc_sig is 0xFFFFFFFF and sum_sig is 0.
- R2: A word accepted while swap_en is 1 leaves with its bytes reversed: output bits 7:0 are input bits 31:24, bits 15:8 are bits 23:16, and so on. With swap_en at 0 the word leaves unchanged. swap_en is sampled in the cycle the word is accepted.
- R3: A word is accepted when in_valid and in_ready are both 1. It appears on out_data with out_valid at 1 from the following clock edge.
- R4: in_ready is 1 when the output register is empty or out_ready is 1, and this follows out_ready in the same cycle. With out_ready held at 1 the stage takes one word per clock. out_valid falls after the held word is taken and no new word is accepted.
- R5: While out_valid is 1 and out_ready is 0, out_data and out_valid do not change.
- R6: sum_sig is the modulo-2^32 sum of the signature words of all accepted words since reset or the last clear.
- R7: crc_sig is a CRC with polynomial 0x04C11DB7 and starting value 0xFFFFFFFF. It has no bit reflection and no final inversion. Each signature word is shifted in whole in one clock, most significant bit first. Both signatures change on the edge that accepts the word.
- R8: With dir_in at 1 (inbound), the signature word is in_data before any swap. With dir_in at 0 (outbound), it is the word as sent on out_data, after any swap.
- R9: A clock with sig_clear at 1 and no accepted word returns crc_sig to 0xFFFFFFFF and sum_sig to 0. If a word is accepted in the same clock, both signatures are computed from those starting values with that word folded in.
- R10: A clock without an accepted word changes neither signature. This covers in_valid without in_ready and in_ready without in_valid.
- R11: sig_clear has no effect on the data path. A word accepted together with a clear leaves as it would without the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word is valid |
| in_ready | output | 1 | Stage can accept a word |
| in_data | input | 32 | Upstream word |
| swap_en | input | 1 | Reverse byte order of accepted words |
| dir_in | input | 1 | 1: input side is the bus side; 0: output side is |
| sig_clear | input | 1 | Return both signatures to their start values |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 32 | Output word |
| crc_sig | output | 32 | Running CRC signature |
| sum_sig | output | 32 | Running additive checksum |

## Verification
A streamed vector table applies words with every combination of swap and direction. The same data is sent with swap on and with direction flipped, so a signature taken on the wrong side of the swap shows up as a different sum and CRC. An all-ones word makes the sum wrap past 2^32, and single-bit words at each end of the word show whether the byte lanes and the CRC shift order are reversed. Directed tests stall the output to separate a held word from a fresh one, and to show that words which are not accepted leave the signatures untouched. They also apply a clear alone and a clear together with an accepted word, to tell "clear then fold" from "fold then clear".

// File: rtl/dma_swap_sig.sv
module dma_swap_sig #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [31:0] CRC_INIT = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              swap_en,
  input  logic              dir_in,
  input  logic              sig_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [31:0]       crc_sig,
  output logic [DATA_W-1:0] sum_sig
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] swapped, line_word, sig_word, q_data, sum_q, sum_base;
  logic [31:0]       crc_q, crc_base;
  logic              q_valid, accept;

  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [DATA_W-1:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign swapped[8*b +: 8] = in_data[8*(NBYTES-1-b) +: 8];
  end

  assign line_word = swap_en ? swapped : in_data;
  assign sig_word  = dir_in ? in_data : line_word;
  assign in_ready  = ~q_valid | out_ready;
  assign accept    = in_valid & in_ready;
  assign crc_base  = sig_clear ? CRC_INIT : crc_q;
  assign sum_base  = sig_clear ? '0 : sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      crc_q   <= CRC_INIT;
      sum_q   <= '0;
    end else begin
      if (in_ready) q_valid <= in_valid;
      if (accept) begin
        q_data <= line_word;
        crc_q  <= crc_fold(crc_base, sig_word);
        sum_q  <= sum_base + sig_word;
      end else if (sig_clear) begin
        crc_q <= CRC_INIT;
        sum_q <= '0;
      end
    end
  end

  assign out_valid = q_valid;
  assign out_data  = q_data;
  assign crc_sig   = crc_q;
  assign sum_sig   = sum_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R3
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !swap_en |=> out_data == $past(in_data)); // R2
  AST_SIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && !sig_clear |=> $stable(crc_sig) && $stable(sum_sig)); // R10
  AST_CLEAR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clear && !(in_valid && in_ready) |=> crc_sig == CRC_INIT && sum_sig == '0); // R9
  AST_SUM_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !sig_clear && dir_in |=> sum_sig == $past(sum_sig) + $past(in_data)); // R6
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R4
endmodule

// File: tb/test_dma_swap_sig.sv
module test_dma_swap_sig;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, swap_en = 1'b0, dir_in = 1'b1, sig_clear = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_data, crc_sig, sum_sig;
  int n_vec = 0, n_bad = 0;
  logic [31:0] e_crc = 32'hFFFFFFFF, e_sum = '0;

  always #2 clk = ~clk;

  dma_swap_sig i_dma_swap_sig (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .swap_en(swap_en), .dir_in(dir_in), .sig_clear(sig_clear), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .crc_sig(crc_sig), .sum_sig(sum_sig));

  // entry: {swap, dir, word in, word out}
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 1'b1, 32'h12345678, 32'h12345678},
    {1'b1, 1'b1, 32'h12345678, 32'h78563412},
    {1'b1, 1'b0, 32'hA1B2C3D4, 32'hD4C3B2A1},
    {1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b1, 1'b1, 32'h00000001, 32'h01000000},
    {1'b1, 1'b0, 32'h00000001, 32'h01000000},
    {1'b0, 1'b1, 32'h80000000, 32'h80000000},
    {1'b1, 1'b1, 32'hDEADBEEF, 32'hEFBEADDE}
  };

  function automatic logic [31:0] crc_bytes(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int k = 3; k >= 0; k--) begin
      r = r ^ ({24'h0, w[8*k +: 8]} << 24);
      for (int j = 0; j < 8; j++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
    end
  endtask

  task automatic fold(input logic [31:0] w);
    e_crc = crc_bytes(e_crc, w);
    e_sum = e_sum + w;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL R4 watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1", "crc", crc_sig, 32'hFFFFFFFF);
    chk("R1", "sum", sum_sig, 32'h0);

    // streamed table, R2 R3 R4 R6 R7 R8
    for (int k = 0; k <= 8; k++) begin
      if (k > 0) begin
        chk("R3", "out_valid", {31'h0, out_valid}, 32'h1);
        chk("R2", "out_data", out_data, VEC[k-1][31:0]);
        chk("R7", "crc", crc_sig, e_crc);
        chk("R6", "sum", sum_sig, e_sum);
      end
      if (k < 8) begin
        swap_en  = VEC[k][65];
        dir_in   = VEC[k][64];
        in_data  = VEC[k][63:32];
        in_valid = 1'b1;
        #0.5;
        chk("R4", "in_ready", {31'h0, in_ready}, 32'h1);
        fold(VEC[k][64] ? VEC[k][63:32] : VEC[k][31:0]); // R8
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    chk("R4", "drain out_valid", {31'h0, out_valid}, 32'h0);
    chk("R10", "idle crc", crc_sig, e_crc);

    // back-pressure, R4 R5 R10
    out_ready = 1'b0; swap_en = 1'b0; dir_in = 1'b1; in_data = 32'h0BADF00D; in_valid = 1'b1;
    fold(32'h0BADF00D);
    @(negedge clk);
    in_data = 32'h11223344;
    chk("R4", "stalled in_ready", {31'h0, in_ready}, 32'h0);
    chk("R3", "stalled data", out_data, 32'h0BADF00D);
    @(negedge clk);
    chk("R5", "held data", out_data, 32'h0BADF00D);
    chk("R5", "held valid", {31'h0, out_valid}, 32'h1);
    chk("R10", "refused crc", crc_sig, e_crc);
    chk("R10", "refused sum", sum_sig, e_sum);
    out_ready = 1'b1;
    #0.5;
    chk("R4", "ready follows", {31'h0, in_ready}, 32'h1);
    fold(32'h11223344);
    @(negedge clk);
    chk("R4", "next word", out_data, 32'h11223344);
    chk("R7", "crc after stall", crc_sig, e_crc);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R4", "drain", {31'h0, out_valid}, 32'h0);
    chk("R10", "ready no valid sum", sum_sig, e_sum);

    // clear alone, R9
    sig_clear = 1'b1;
    @(negedge clk);
    sig_clear = 1'b0;
    chk("R9", "clear crc", crc_sig, 32'hFFFFFFFF);
    chk("R9", "clear sum", sum_sig, 32'h0);

    // clear with word, R9 R11
    e_crc = 32'hFFFFFFFF; e_sum = '0;
    sig_clear = 1'b1; in_valid = 1'b1; swap_en = 1'b1; dir_in = 1'b0; in_data = 32'hCAFE0102;
    fold(32'h0201FECA);
    @(negedge clk);
    sig_clear = 1'b0; in_valid = 1'b0;
    chk("R11", "data with clear", out_data, 32'h0201FECA);
    chk("R9", "crc clear+word", crc_sig, e_crc);
    chk("R9", "sum clear+word", sum_sig, e_sum);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule